// File: doc/BRIEF.md
# Single-Item Vending Controller

This block sequences a vending machine that sells one product at a fixed price of 75 cents. An external tallier compares the running coin total with the price and reports the result as three exclusive flags: total short, total exact, total over. A separate flag says whether the machine can make change. From these inputs, a coin strobe and a refund button, the controller decides whether to wait for more coins, release the product, pay change and then release, or refund every coin.

The controller is a Moore machine. Its six states are held one-hot in six flip-flops. Each of the three command outputs comes from a flip-flop that is loaded from the next-state logic, so it is high in exactly the same cycles as its state. A synchronous active-high reset returns the machine to the idle state. The state vector is brought out so that the integrator can observe which step the machine is in.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is idle whatever the other inputs are. Idle is encoded on `state_o` as 6'b000001, and all three command outputs are low.
- R2: In idle with `coin_i` high, the next state is tally (6'b000010). This holds even when `refund_req_i` is high in the same cycle, because the coin takes priority.
- R3: In idle with `coin_i` low, the next state is refund (6'b100000) if `refund_req_i` is high. Otherwise the machine stays in idle.
- R4: In tally, the next state is idle if `short_i` is set, vend (6'b000100) if `exact_i` is set, and change-check (6'b001000) if `over_i` is set.
- R5: In change-check, the next state is pay-change (6'b010000) if `change_ok_i` is high, and refund otherwise.
- R6: Pay-change always goes to vend, and vend and refund always go to idle, whatever the inputs are.
- R7: `vend_o` is high only in vend, `change_o` only in pay-change, and `refund_o` only in refund. State bit 2 is vend, bit 4 is pay-change and bit 5 is refund.
- R8: After every clock edge that follows reset, exactly one bit of `state_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_i | input | 1 | A coin was deposited this cycle |
| refund_req_i | input | 1 | Refund button pressed |
| short_i | input | 1 | Tallied total is below the price |
| exact_i | input | 1 | Tallied total equals the price |
| over_i | input | 1 | Tallied total is above the price |
| change_ok_i | input | 1 | Change can be paid out |
| vend_o | output | 1 | Release the product |
| change_o | output | 1 | Pay out change |
| refund_o | output | 1 | Return all deposited coins |
| state_o | output | 6 | One-hot state vector |

## Verification
Two events can arrive in the same idle cycle: a coin deposit and a refund request. The bench drives both high together and expects the machine to enter tally, with no refund pulse. A second collision is reset arriving together with a transition: the bench asserts reset while the machine is in tally with the exact flag set, and expects idle with no vend pulse. Every path is walked and checked state by state, including the refund taken when no change is available.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int NST    = 6;
  localparam int NCMD   = 3;
  localparam int B_IDLE = 0;
  localparam int B_TALLY = 1;
  localparam int B_VEND = 2;
  localparam int B_CCHK = 3;
  localparam int B_PAYC = 4;
  localparam int B_RFND = 5;
  typedef logic [NST-1:0] st_t;
  localparam st_t S_IDLE = st_t'(1) << B_IDLE;
endpackage

// File: rtl/vend_next.sv
module vend_next
  import vend_pkg::*;
(
  input  st_t  cur,
  input  logic coin,
  input  logic rfq,
  input  logic short_f,
  input  logic exact_f,
  input  logic over_f,
  input  logic chg_ok,
  output st_t  nxt
);
  logic legal;
  st_t  raw;

  // the state is legal only when exactly one bit is set
  assign legal = (cur != '0) && ((cur & (cur - st_t'(1))) == '0);

  always_comb begin
    raw          = '0;
    raw[B_IDLE]  = (cur[B_IDLE] & ~coin & ~rfq)
                 | (cur[B_TALLY] & ~over_f & ~exact_f)
                 | cur[B_VEND] | cur[B_RFND];
    raw[B_TALLY] = cur[B_IDLE] & coin;
    raw[B_VEND]  = (cur[B_TALLY] & exact_f & ~over_f) | cur[B_PAYC];
    raw[B_CCHK]  = cur[B_TALLY] & over_f;
    raw[B_PAYC]  = cur[B_CCHK] & chg_ok;
    raw[B_RFND]  = (cur[B_IDLE] & ~coin & rfq) | (cur[B_CCHK] & ~chg_ok);
    nxt          = legal ? raw : S_IDLE;
  end
endmodule

// File: rtl/vend_reg.sv
module vend_reg #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           coin_i,
  input  logic           refund_req_i,
  input  logic           short_i,
  input  logic           exact_i,
  input  logic           over_i,
  input  logic           change_ok_i,
  output logic           vend_o,
  output logic           change_o,
  output logic           refund_o,
  output logic [NST-1:0] state_o
);
  st_t             cur, nxt;
  logic [NCMD-1:0] cmd_d, cmd_q;

  vend_next u_next (
    .cur(cur), .coin(coin_i), .rfq(refund_req_i), .short_f(short_i),
    .exact_f(exact_i), .over_f(over_i), .chg_ok(change_ok_i), .nxt(nxt)
  );

  vend_reg #(.W(NST), .RST_VAL(S_IDLE)) u_state (
    .clk(clk), .rst(rst), .d(nxt), .q(cur)
  );

  // command flops load from the next state, so each one is in step with its state bit
  assign cmd_d = {nxt[B_RFND], nxt[B_PAYC], nxt[B_VEND]};

  vend_reg #(.W(NCMD), .RST_VAL('0)) u_cmd (
    .clk(clk), .rst(rst), .d(cmd_d), .q(cmd_q)
  );

  assign vend_o   = cmd_q[0];
  assign change_o = cmd_q[1];
  assign refund_o = cmd_q[2];
  assign state_o  = cur;
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk
  import vend_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic           coin_i,
  input logic           refund_req_i,
  input logic           exact_i,
  input logic           over_i,
  input logic           change_ok_i,
  input logic           vend_o,
  input logic           change_o,
  input logic           refund_o,
  input logic [NST-1:0] state_o
);
  // R8
  onehot_state_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(state_o) == 1);
  // R7
  vend_match_chk: assert property (@(posedge clk) disable iff (rst)
    vend_o == state_o[B_VEND]);
  // R7
  cmd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({vend_o, change_o, refund_o}));
  // R2
  coin_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o[B_IDLE] && coin_i) |=> state_o[B_TALLY]);
  // R4
  exact_vend_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o[B_TALLY] && exact_i && !over_i) |=> vend_o);
  // R5
  no_change_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o[B_CCHK] && !change_ok_i) |=> refund_o);
  // R6
  payc_vend_chk: assert property (@(posedge clk) disable iff (rst)
    change_o |=> vend_o);
  // R3
  refund_req_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o[B_IDLE] && !coin_i && refund_req_i) |=> refund_o);
endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .coin_i(coin_i), .refund_req_i(refund_req_i),
  .exact_i(exact_i), .over_i(over_i), .change_ok_i(change_ok_i),
  .vend_o(vend_o), .change_o(change_o), .refund_o(refund_o), .state_o(state_o)
);

// File: tb/vend_ctrl_tb_top.sv
`timescale 1ns/1ps
module vend_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coin = 0, rfq = 0, sh = 0, ex = 0, ov = 0, ok = 0;
  logic vend, chg, rfd;
  logic [5:0] st;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [5:0] IDLE = 6'b000001, TALLY = 6'b000010, VEND = 6'b000100,
                         CCHK = 6'b001000, PAYC = 6'b010000, RFND = 6'b100000;

  always #4 clk = ~clk;

  vend_ctrl dut_i (
    .clk(clk), .rst(rst), .coin_i(coin), .refund_req_i(rfq), .short_i(sh),
    .exact_i(ex), .over_i(ov), .change_ok_i(ok), .vend_o(vend), .change_o(chg),
    .refund_o(rfd), .state_o(st)
  );

  task automatic expect_st(input logic [5:0] e, input string req);
    logic [2:0] eo, ao;
    eo = {e[5], e[4], e[2]};
    ao = {rfd, chg, vend};
    checks++;
    if (st !== e || ao !== eo) begin
      errors++;
      $display("FAIL %s state=%b cmd=%b expected state=%b cmd=%b", req, st, ao, e, eo);
    end
    checks++;
    if ($countones(st) != 1) begin
      errors++;
      $display("FAIL R8 state=%b expected one bit set", st);
    end
  endtask

  task automatic step(input logic c, r, s, e, o, k);
    @(negedge clk);
    coin = c; rfq = r; sh = s; ex = e; ov = o; ok = k;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1; coin = 1; rfq = 1;
    @(posedge clk); #1;
    expect_st(IDLE, "R1");
    @(negedge clk); rst = 0; coin = 0; rfq = 0;
  endtask

  task automatic t_exact;
    step(1,0,0,0,0,0); expect_st(TALLY, "R2");
    step(0,0,0,1,0,0); expect_st(VEND, "R4 R7");
    step(1,1,0,1,1,1); expect_st(IDLE, "R6");
  endtask

  task automatic t_change;
    step(1,0,0,0,0,0); expect_st(TALLY, "R2");
    step(0,0,0,0,1,1); expect_st(CCHK, "R4");
    step(0,0,0,0,0,1); expect_st(PAYC, "R5 R7");
    step(1,1,0,0,0,0); expect_st(VEND, "R6");
    step(0,0,0,0,0,0); expect_st(IDLE, "R6");
  endtask

  task automatic t_nochange;
    step(1,0,0,0,0,0); expect_st(TALLY, "R2");
    step(0,0,0,0,1,0); expect_st(CCHK, "R4");
    step(0,0,0,0,0,0); expect_st(RFND, "R5 R7");
    step(1,0,0,0,0,0); expect_st(IDLE, "R6");
  endtask

  task automatic t_short;
    step(1,0,0,0,0,0); expect_st(TALLY, "R2");
    step(0,0,1,0,0,0); expect_st(IDLE, "R4");
  endtask

  task automatic t_both;
    step(1,1,0,0,0,0); expect_st(TALLY, "R2 coin over refund");
    step(0,0,1,0,0,0); expect_st(IDLE, "R4");
  endtask

  task automatic t_refund;
    step(0,0,0,0,0,0); expect_st(IDLE, "R3 hold");
    step(0,1,0,0,0,0); expect_st(RFND, "R3 R7");
    step(0,1,0,0,0,0); expect_st(IDLE, "R6");
  endtask

  task automatic t_reset_mid;
    step(1,0,0,0,0,0); expect_st(TALLY, "R2");
    @(negedge clk); rst = 1; ex = 1; coin = 0;
    @(posedge clk); #1;
    expect_st(IDLE, "R1 reset over vend");
    @(negedge clk); rst = 0; ex = 0;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset;
    t_exact;
    t_change;
    t_nochange;
    t_short;
    t_both;
    t_refund;
    t_reset_mid;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule